// File: doc/BRIEF.md
# Pipelined Odd-Even Transposition Sorter

This block sorts a vector of six unsigned 4-bit numbers into ascending order using a fixed network of compare-exchange stages. Each stage compares fixed neighbouring pairs of lanes and swaps any pair that is out of order. The stages alternate between pairs that begin on even lanes and pairs that begin on odd lanes. Six such stages are enough to sort any arrangement of six values, and each stage ends in a register.

A new vector may be presented on every clock cycle. Exactly six cycles later the sorted vector appears at the output, together with a copy of the input valid flag. Once the pipeline has filled, one sorted vector leaves the block on every clock cycle. The output cannot stall the block, and a vector cannot finish early.

Top module: `oet_sort_pipe`

## Requirements
- R1: Lane k of the packed input and output buses occupies bits [4k+3:4k], for k from 0 to 5, and holds an unsigned 4-bit value.
- R2: When `rst_n` is low at a rising clock edge, every valid flag in the pipeline is cleared, so `out_vld` reads 0 after that edge.
- R3: `out_vld` is equal to the value that `in_vld` had six rising edges earlier, provided no reset occurred in between.
- R4: The output vector is in ascending order, with lane 0 holding the smallest value and lane 5 the largest.
- R5: The output vector holds the same multiset of values as the input vector accepted six cycles earlier, including any repeated values.
- R6: A new vector is accepted on every cycle that `in_vld` is high, and back-to-back vectors each produce their own sorted result on consecutive cycles.
- R7: Stage s compares the lane pairs (0,1), (2,3) and (4,5) when s is even, and the pairs (1,2) and (3,4) when s is odd. Stage 0 uses the even pairs. Each compare-exchange swaps a pair only when its lower lane holds the strictly larger value.
- R8: Cycles where `in_vld` is low produce cycles where `out_vld` is low. They do not change the results of valid vectors before or after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid flags |
| in_vld | input | 1 | High when `in_data` holds a vector to sort |
| in_data | input | 24 | Six 4-bit lanes; lane k is at bits [4k+3:4k] |
| out_vld | output | 1 | High when `out_data` holds a sorted vector |
| out_data | output | 24 | The sorted vector, ascending from lane 0 |

## Verification
The assertions assume that `in_data` holds defined values whenever `in_vld` is high. They check latency, order and content only on vectors that are marked valid, and they do not look at lanes that carry no data. The stimulus meets this assumption because it drives defined values on every cycle, including cycles where `in_vld` is low. It mixes random vectors with directed ones (all equal, reversed, already sorted, extreme values) and random gaps in `in_vld`. The checker compares each valid output with the input from six cycles earlier, using a delay line of its own. It counts how many times each value appears in the two vectors and requires the counts to match.

// File: rtl/oet_sort_pkg.sv
// Package oet_sort_pkg
// Holds the lane and width parameters and the vector type shared by the
// sorter modules. Assumes all lanes are the same width.
package oet_sort_pkg;
    localparam int LANES  = 6;
    localparam int LANE_W = 4;
    localparam int VEC_W  = LANES * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] vec_t;
endpackage

// File: rtl/oet_cmp_swap.sv
// Module oet_cmp_swap
// Compare-exchange element. Places the smaller value on lo_o and the larger
// on hi_o. Swaps only when lo_i is strictly greater than hi_i, so equal
// values stay where they are. Purely combinational.
module oet_cmp_swap #(
    parameter int W = 4
) (
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic [W-1:0] lo_o,
    output logic [W-1:0] hi_o
);
    logic swap;

    // Decide whether the pair is out of order
    always_comb swap = (lo_i > hi_i);

    // Route the pair according to that decision
    always_comb begin
        lo_o = swap ? hi_i : lo_i;
        hi_o = swap ? lo_i : hi_i;
    end
endmodule

// File: rtl/oet_stage.sv
// Module oet_stage
// One registered stage of the network. ODD_PHASE=0 pairs the lanes that
// start on even indices; ODD_PHASE=1 pairs the lanes that start on odd
// indices. Lanes left without a partner pass straight through. The valid
// flag resets synchronously (active low); the data registers have no reset.
module oet_stage #(
    parameter int N         = 6,
    parameter int W         = 4,
    parameter bit ODD_PHASE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [N*W-1:0]   dat_i,
    output logic             vld_o,
    output logic [N*W-1:0]   dat_o
);
    localparam int FIRST = ODD_PHASE ? 1 : 0;

    logic [N*W-1:0] nxt;

    // Build the compare-exchange pairs and the lanes that pass through
    for (genvar k = 0; k < N; k++) begin : g_lane
        if ((k >= FIRST) && (((k - FIRST) % 2) == 0) && (k + 1 < N)) begin : g_pair
            oet_cmp_swap #(.W(W)) u_cs (
                .lo_i (dat_i[k*W +: W]),
                .hi_i (dat_i[(k+1)*W +: W]),
                .lo_o (nxt[k*W +: W]),
                .hi_o (nxt[(k+1)*W +: W])
            );
        end else if (!((k > FIRST) && (((k - 1 - FIRST) % 2) == 0))) begin : g_pass
            assign nxt[k*W +: W] = dat_i[k*W +: W];
        end
    end

    // Register the valid flag; reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Register the stage data; no reset needed
    always_ff @(posedge clk) begin
        dat_o <= nxt;
    end
endmodule

// File: rtl/oet_sort_pipe.sv
// Module oet_sort_pipe (top)
// Pipelined odd-even transposition sorter. It has STAGES registered stages
// that alternate between even and odd pairing, starting with even pairing.
// It accepts one vector per cycle and has a latency of STAGES cycles. The
// network needs STAGES >= N to sort every possible input.
module oet_sort_pipe
    import oet_sort_pkg::*;
#(
    parameter int N      = LANES,
    parameter int W      = LANE_W,
    parameter int STAGES = LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [N*W-1:0]   in_data,
    output logic             out_vld,
    output logic [N*W-1:0]   out_data
);
    logic [STAGES:0]        vld_c;
    logic [N*W-1:0]         dat_c [STAGES+1];

    // Feed the first stage from the block inputs
    always_comb begin
        vld_c[0] = in_vld;
        dat_c[0] = in_data;
    end

    // Chain the stages, alternating the pairing phase
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        oet_stage #(
            .N         (N),
            .W         (W),
            .ODD_PHASE (1'((s % 2) == 1))
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_c[s]),
            .dat_i (dat_c[s]),
            .vld_o (vld_c[s+1]),
            .dat_o (dat_c[s+1])
        );
    end

    // Drive the outputs from the last stage
    always_comb begin
        out_vld  = vld_c[STAGES];
        out_data = dat_c[STAGES];
    end
endmodule

// File: rtl/oet_sort_pipe_chk.sv
// Module oet_sort_pipe_chk
// Checker bound to oet_sort_pipe. It keeps its own six-deep delay line of
// the inputs and compares it with the outputs. Assumes in_data is defined
// whenever in_vld is high.
module oet_sort_pipe_chk #(
    parameter int N      = 6,
    parameter int W      = 4,
    parameter int STAGES = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_vld,
    input logic [N*W-1:0] in_data,
    input logic           out_vld,
    input logic [N*W-1:0] out_data
);
    logic           h_vld [STAGES];
    logic [N*W-1:0] h_dat [STAGES];
    logic [3:0]     since_rst;
    logic           ordered;
    logic           same_set;

    // Delay line of inputs, independent of the design's stages
    always_ff @(posedge clk) begin
        h_vld[0] <= in_vld;
        h_dat[0] <= in_data;
        for (int i = 1; i < STAGES; i++) begin
            h_vld[i] <= h_vld[i-1];
            h_dat[i] <= h_dat[i-1];
        end
    end

    // Count the cycles since reset, saturating at 15
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 15) since_rst <= since_rst + 1'b1;
    end

    // Work out whether the output is ordered and matches the delayed input
    always_comb begin
        ordered  = 1'b1;
        same_set = 1'b1;
        for (int k = 0; k + 1 < N; k++)
            if (out_data[k*W +: W] > out_data[(k+1)*W +: W]) ordered = 1'b0;
        for (int v = 0; v < (1 << W); v++) begin
            int ca, cb;
            ca = 0;
            cb = 0;
            for (int k = 0; k < N; k++) begin
                if (out_data[k*W +: W] == W'(v))            ca++;
                if (h_dat[STAGES-1][k*W +: W] == W'(v))     cb++;
            end
            if (ca != cb) same_set = 1'b0;
        end
    end

    // R2
    rst_clears_vld_chk: assert property (@(posedge clk)
        !rst_n |=> !out_vld);

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(STAGES)) |-> (out_vld == h_vld[STAGES-1]));

    // R4
    out_ordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ordered);

    // R5
    out_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && since_rst >= 4'(STAGES)) |-> same_set);
endmodule

bind oet_sort_pipe oet_sort_pipe_chk #(.N(N), .W(W), .STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data)
);

// File: tb/sim_oet_sort_pipe.sv
// Bench for oet_sort_pipe: mixes directed and seeded random vectors and
// checks every output cycle against a reference queue built by bench
// functions.
module sim_oet_sort_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 6;
    localparam int W   = 4;
    localparam int LAT = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_vld;
    logic [N*W-1:0] in_data;
    logic           out_vld;
    logic [N*W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    logic           exp_vld [LAT];
    logic [N*W-1:0] exp_dat [LAT];

    oet_sort_pipe u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .out_vld(out_vld), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: sort the lanes of a vector into ascending order
    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        logic [W-1:0] a [N];
        logic [W-1:0] t;
        for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
        for (int i = 0; i < N; i++)
            for (int j = 0; j + 1 < N - i; j++)
                if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
        for (int i = 0; i < N; i++) ref_sort[i*W +: W] = a[i];
    endfunction

    // Record a check result
    task automatic check(input string req, input logic [N*W-1:0] act,
                         input logic [N*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle, then compare the output at mid-cycle
    task automatic step(input logic v, input logic [N*W-1:0] d, input string req);
        in_vld  = v;
        in_data = d;
        @(posedge clk);
        for (int i = LAT-1; i > 0; i--) begin
            exp_vld[i] = exp_vld[i-1];
            exp_dat[i] = exp_dat[i-1];
        end
        exp_vld[0] = v;
        exp_dat[0] = ref_sort(d);
        #(CLK_PERIOD/2);
        // R3 R8: the output valid flag follows the input six cycles later
        check({req, " R3 vld"}, {23'd0, out_vld}, {23'd0, exp_vld[LAT-1]});
        // R4 R5 R6 R7: every valid output is the sorted input
        if (exp_vld[LAT-1]) check({req, " R4 data"}, out_data, exp_dat[LAT-1]);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        rst_n = 1'b0; in_vld = 1'b1; in_data = '0;
        for (int i = 0; i < LAT; i++) begin exp_vld[i] = 1'b0; exp_dat[i] = '0; end
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        // R2: reset holds the output valid flag low
        check("R2 reset", {23'd0, out_vld}, 24'd0);
        rst_n = 1'b1;
        // R1 R7: directed corner cases (lane 0 at bits [3:0])
        step(1, 24'h012345, "R1 reversed");
        step(1, 24'h543210, "R7 sorted");
        step(1, 24'h777777, "R5 all equal");
        step(1, 24'hF0F0F0, "R5 extremes");
        step(1, 24'h0000F0, "R7 max walks");
        step(0, 24'hABCDEF, "R8 gap");
        step(1, 24'h0FFFFF, "R7 min walks");
        step(1, 24'h112233, "R5 dup pairs");
        for (int i = 0; i < LAT + 2; i++) step(0, 24'h000000, "R8 idle");
        // R6: back-to-back random vectors, with random gaps mixed in
        for (int i = 0; i < 400; i++)
            step(($urandom % 4) != 0, 24'($urandom), "R6 random");
        for (int i = 0; i < LAT; i++) step(0, 24'h0, "R8 drain");
        // R2: reset in mid-stream clears the valid flags in flight
        step(1, 24'h123456, "R2 pre");
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/2);
        check("R2 mid reset", {23'd0, out_vld}, 24'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule